// File: doc/BRIEF.md
# Forced Link and Configuration Detect Controller

This block decides whether a fixed 1000 Mb/s fiber physical coding sublayer reports its link as up. The link can come from two places. When auto-negotiation is off, software can force the link up with a set-link-up control bit. The forced link only holds while no loss-of-signal is reported and receive synchronization is present. When auto-negotiation is on, the link follows the negotiation engine's completion flag gated by receive sync. In that case the set-link-up bit and the loss-of-signal input have no effect.

The block also watches a strobe that marks each received configuration ordered set. A forced-link partner that starts negotiating sends such sets. Each one sets a sticky cause bit, which software clears by writing one to it. The interrupt output is the cause bit gated by an enable bit. A speed status field always reports the single supported rate. The negotiation engine and the register bus sit outside this block.

Top module: `fiber_link_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, link_up is 0, link_n is 1, cfg_cause is 0 and cfg_irq is 0.
- R2: With an_enable=0, force_link=1, los=0 and rx_sync=1 sampled at a rising edge, link_up is 1 after that edge.
- R3: With an_enable=0 and a forced link, los=1 or rx_sync=0 sampled at a rising edge makes link_up 0 after that same edge.
- R4: With an_enable=1, link_up after an edge equals an_complete AND rx_sync sampled at that edge, whatever force_link and los are.
- R5: With an_enable=0 and force_link=0, link_up is 0 after the edge, whatever los, rx_sync and an_complete are.
- R6: link_n is always the complement of link_up (active-low indicator).
- R7: speed_code always reads 2'b10, meaning 1000 Mb/s.
- R8: cfg_rx_seen=1 at an edge makes cfg_cause 1 after it. Once cfg_cause is set, it stays 1 until it is cleared.
- R9: cfg_cause_clr=1 at an edge clears cfg_cause after it, unless cfg_rx_seen is also 1 at that edge, in which case the set wins.
- R10: cfg_irq after an edge equals the new cfg_cause value AND cfg_irq_en sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_link | input | 1 | Set-link-up control bit |
| an_enable | input | 1 | Auto-negotiation enable bit |
| los | input | 1 | Loss-of-signal, active high |
| rx_sync | input | 1 | Receive synchronization acquired |
| an_complete | input | 1 | Negotiation complete from the negotiation engine |
| cfg_rx_seen | input | 1 | Pulse per received configuration ordered set |
| cfg_cause_clr | input | 1 | Write-one-to-clear pulse for the cause bit |
| cfg_irq_en | input | 1 | Interrupt enable for the cause bit |
| link_up | output | 1 | Registered link status |
| link_n | output | 1 | Registered active-low link indicator |
| speed_code | output | SPEED_W | Speed status, constant 2'b10 |
| cfg_cause | output | 1 | Sticky configuration-received cause bit |
| cfg_irq | output | 1 | Gated interrupt request |

## Verification
Every output comes out of a single register stage. A change at the inputs therefore shows at the outputs after exactly one rising edge: link_up and link_n from the link inputs, and cfg_cause and cfg_irq from the strobe, clear and enable. The bench drives each stimulus just after a falling edge and samples one full period later, at the next falling edge, so every read falls after exactly one register update. It sweeps all 32 combinations of the five link inputs in sequence, so each case also starts from a different previous link state. It sweeps all 16 combinations of prior cause, strobe, clear and enable, then checks stickiness over idle cycles and a forced-link drop on a single edge.

// File: rtl/fiber_link_pkg.sv
package fiber_link_pkg;
  localparam int SPEED_W_DEF = 2;
  localparam logic [SPEED_W_DEF-1:0] SPEED_GIG = 2'b10;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FORCED = 2'd1,
    SRC_NEG    = 2'd2
  } link_src_e;
endpackage

// File: rtl/link_arbiter.sv
module link_arbiter
  import fiber_link_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic force_link,
  input  logic an_enable,
  input  logic los,
  input  logic rx_sync,
  input  logic an_complete,
  output logic link_q,
  output logic link_nq
);
  link_src_e src;
  logic      link_d;

  always_comb begin
    if (an_enable)       src = SRC_NEG;
    else if (force_link) src = SRC_FORCED;
    else                 src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_NEG:    link_d = an_complete & rx_sync;
      SRC_FORCED: link_d = ~los & rx_sync;
      default:    link_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q  <= 1'b0;
      link_nq <= 1'b1;
    end else begin
      link_q  <= link_d;
      link_nq <= ~link_d;
    end
  end

  AST_FORCED_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!$past(an_enable) && ($past(los) || !$past(rx_sync))) |-> !link_q); // R3
  AST_NEG_FOLLOWS_DOWN: assert property (@(posedge clk) disable iff (rst)
    ($past(an_enable) && !($past(an_complete) && $past(rx_sync))) |-> !link_q); // R4
  AST_NEG_FOLLOWS_UP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(an_enable) && $past(an_complete) && $past(rx_sync)) |-> link_q); // R4
  AST_NO_SLU_NO_LINK: assert property (@(posedge clk) disable iff (rst)
    (!$past(an_enable) && !$past(force_link)) |-> !link_q); // R5
endmodule

// File: rtl/cfg_irq_unit.sv
module cfg_irq_unit (
  input  logic clk,
  input  logic rst,
  input  logic cfg_rx_seen,
  input  logic cfg_cause_clr,
  input  logic cfg_irq_en,
  output logic cause_q,
  output logic irq_q
);
  logic cause_d;

  always_comb cause_d = cfg_rx_seen | (cause_q & ~cfg_cause_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= cause_d & cfg_irq_en;
    end
  end

  AST_STROBE_SETS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_rx_seen)) |-> cause_q); // R8
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cause_q) && !$past(cfg_cause_clr)) |-> cause_q); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_cause_clr) && !$past(cfg_rx_seen)) |-> !cause_q); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_irq_en) |-> !irq_q); // R10
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> cause_q); // R10
endmodule

// File: rtl/fiber_link_ctrl.sv
module fiber_link_ctrl
  import fiber_link_pkg::*;
#(
  parameter int SPEED_W = SPEED_W_DEF,
  parameter logic [SPEED_W-1:0] SPEED_VAL = SPEED_GIG
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               force_link,
  input  logic               an_enable,
  input  logic               los,
  input  logic               rx_sync,
  input  logic               an_complete,
  input  logic               cfg_rx_seen,
  input  logic               cfg_cause_clr,
  input  logic               cfg_irq_en,
  output logic               link_up,
  output logic               link_n,
  output logic [SPEED_W-1:0] speed_code,
  output logic               cfg_cause,
  output logic               cfg_irq
);
  logic [SPEED_W-1:0] speed_q;

  link_arbiter u_arb (
    .clk         (clk),
    .rst         (rst),
    .force_link  (force_link),
    .an_enable   (an_enable),
    .los         (los),
    .rx_sync     (rx_sync),
    .an_complete (an_complete),
    .link_q      (link_up),
    .link_nq     (link_n)
  );

  cfg_irq_unit u_irq (
    .clk           (clk),
    .rst           (rst),
    .cfg_rx_seen   (cfg_rx_seen),
    .cfg_cause_clr (cfg_cause_clr),
    .cfg_irq_en    (cfg_irq_en),
    .cause_q       (cfg_cause),
    .irq_q         (cfg_irq)
  );

  always_ff @(posedge clk) begin
    speed_q <= SPEED_VAL;
  end
  assign speed_code = speed_q;

  AST_LINK_N_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    link_n == !link_up); // R6
endmodule

// File: tb/fiber_link_ctrl_bench.sv
module fiber_link_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic force_link, an_enable, los, rx_sync, an_complete;
  logic cfg_rx_seen, cfg_cause_clr, cfg_irq_en;
  logic link_up, link_n, cfg_cause, cfg_irq;
  logic [1:0] speed_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fiber_link_ctrl u_fiber_link_ctrl (
    .clk(clk), .rst(rst), .force_link(force_link), .an_enable(an_enable),
    .los(los), .rx_sync(rx_sync), .an_complete(an_complete),
    .cfg_rx_seen(cfg_rx_seen), .cfg_cause_clr(cfg_cause_clr), .cfg_irq_en(cfg_irq_en),
    .link_up(link_up), .link_n(link_n), .speed_code(speed_code),
    .cfg_cause(cfg_cause), .cfg_irq(cfg_irq)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_irq();
    cfg_rx_seen = 0; cfg_cause_clr = 0;
  endtask

  initial begin
    rst = 1; force_link = 0; an_enable = 0; los = 0; rx_sync = 0; an_complete = 0;
    cfg_rx_seen = 0; cfg_cause_clr = 0; cfg_irq_en = 0;
    repeat (4) @(negedge clk);
    chk("R1 link_up in reset", {1'b0, link_up}, 2'b00);
    chk("R1 link_n in reset", {1'b0, link_n}, 2'b01);
    chk("R1 cause in reset", {1'b0, cfg_cause}, 2'b00);
    chk("R1 irq in reset", {1'b0, cfg_irq}, 2'b00);
    rst = 0;
    @(negedge clk);
    chk("R1 link_up after reset", {1'b0, link_up}, 2'b00);
    chk("R1 cause after reset", {1'b0, cfg_cause}, 2'b00);
    chk("R7 speed after reset", speed_code, 2'b10);

    // Exhaustive link-input sweep
    for (int i = 0; i < 32; i++) begin
      logic e_ane, e_slu, e_los, e_sync, e_done, e_link;
      string tag;
      {e_ane, e_slu, e_los, e_sync, e_done} = i[4:0];
      an_enable = e_ane; force_link = e_slu; los = e_los; rx_sync = e_sync; an_complete = e_done;
      e_link = e_ane ? (e_done & e_sync) : (e_slu & ~e_los & e_sync);
      if (e_ane) tag = "R4 negotiated link";
      else if (!e_slu) tag = "R5 no force";
      else if (e_link) tag = "R2 forced up";
      else tag = "R3 forced dropped";
      @(negedge clk);
      chk(tag, {1'b0, link_up}, {1'b0, e_link});
      chk("R6 link_n complement", {1'b0, link_n}, {1'b0, ~e_link});
      chk("R7 speed code", speed_code, 2'b10);
    end

    // Forced link drops on one edge: LOS, then sync loss
    an_enable = 0; force_link = 1; los = 0; rx_sync = 1; an_complete = 0;
    @(negedge clk);
    chk("R2 forced up again", {1'b0, link_up}, 2'b01);
    los = 1;
    @(negedge clk);
    chk("R3 los drops link", {1'b0, link_up}, 2'b00);
    los = 0;
    @(negedge clk);
    chk("R2 forced up after los", {1'b0, link_up}, 2'b01);
    rx_sync = 0;
    @(negedge clk);
    chk("R3 sync loss drops link", {1'b0, link_up}, 2'b00);
    chk("R6 link_n high on drop", {1'b0, link_n}, 2'b01);

    // Exhaustive interrupt sweep: prior cause x strobe x clear x enable
    for (int j = 0; j < 16; j++) begin
      logic p_cause, e_stb, e_clr, e_en, e_cause;
      {p_cause, e_stb, e_clr, e_en} = j[3:0];
      cfg_irq_en = 0;
      cfg_rx_seen = p_cause; cfg_cause_clr = ~p_cause;
      @(negedge clk);
      chk("R8 preset cause", {1'b0, cfg_cause}, {1'b0, p_cause});
      cfg_rx_seen = e_stb; cfg_cause_clr = e_clr; cfg_irq_en = e_en;
      e_cause = e_stb | (p_cause & ~e_clr);
      @(negedge clk);
      chk(e_clr ? "R9 clear vs set" : "R8 set or hold", {1'b0, cfg_cause}, {1'b0, e_cause});
      chk("R10 irq gate", {1'b0, cfg_irq}, {1'b0, e_cause & e_en});
    end

    // Stickiness over idle cycles
    cfg_irq_en = 1; cfg_rx_seen = 1; cfg_cause_clr = 0;
    @(negedge clk);
    idle_irq();
    repeat (5) @(negedge clk);
    chk("R8 cause sticky", {1'b0, cfg_cause}, 2'b01);
    chk("R10 irq while enabled", {1'b0, cfg_irq}, 2'b01);
    cfg_irq_en = 0;
    @(negedge clk);
    chk("R10 irq masked", {1'b0, cfg_irq}, 2'b00);
    chk("R8 cause kept under mask", {1'b0, cfg_cause}, 2'b01);
    cfg_cause_clr = 1;
    @(negedge clk);
    cfg_cause_clr = 0;
    chk("R9 w1c clears", {1'b0, cfg_cause}, 2'b00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule